// File: doc/BRIEF.md
# Timer Channel Capture/Compare Register

This block is one 16-bit timer channel built around a single data register that serves two purposes. A mode input picks the role. In compare mode the register holds a reload value: a down-counter starts from it, runs to zero, reloads and raises a one-cycle interrupt pulse on each reload, so it produces a periodic tick. In capture mode the counter runs upward freely, and each selected edge of an external timer input copies the running count into the data register and raises the interrupt pulse.

Software reaches the register through a simple write strobe with byte enables and a read bus that always returns the full word. With the split control off, every write replaces all 16 bits and the byte enables are ignored. With split on, each byte lane is written only when its enable is set. The timer input is asynchronous and passes through a two-flop synchroniser before edge detection. A capture and a software write in the same cycle resolve in favour of the capture.

Top module: `timer_cc_channel`

## Requirements
- R1: While reset is asserted and right after it, the data register reads 0x0000, the counter reads 0x0000 and the interrupt is low.
- R2: With split_en low, a cycle with wr_en high replaces all 16 bits of the data register on the next clock edge, whatever wr_be holds, and rd_data always presents the whole 16-bit word.
- R3: In compare mode (mode_capture = 0), while the counter is non-zero it drops by exactly one per clock.
- R4: In compare mode, a clock edge that finds the counter at zero loads the current data register value into the counter and raises irq for exactly that one cycle, so a data value D gives an irq period of D+1 clocks.
- R5: In compare mode, edges on tmr_in never change the data register.
- R6: In capture mode (mode_capture = 1), a valid edge on tmr_in copies the counter value into the data register on the third clock edge after the input changes. The copied value is the one the counter held just before that edge, and irq is high for exactly the one cycle after the capture.
- R7: Any change of mode_capture clears the counter on the next edge. In capture mode the counter then counts up by one per clock and wraps from 0xFFFF to 0x0000.
- R8: edge_sel picks the valid capture edge: 2'b00 none, 2'b01 rising, 2'b10 falling, 2'b11 both. Edges that are not selected cause neither a capture nor an irq.
- R9: With split_en high, wr_be[0] enables writing bits 7:0 and wr_be[1] enables writing bits 15:8. A lane whose enable is low keeps its old value.
- R10: If a capture and a software write occur in the same cycle, the data register takes the captured count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_capture | input | 1 | 0 = compare (reload) role, 1 = capture role |
| edge_sel | input | 2 | Valid capture edge: 00 none, 01 rising, 10 falling, 11 both |
| split_en | input | 1 | Enables independent byte-lane writes |
| tmr_in | input | 1 | Asynchronous external timer input |
| wr_en | input | 1 | Software write strobe |
| wr_be | input | 2 | Byte enables, bit 0 = low byte, bit 1 = high byte (used only when split_en is high) |
| wr_data | input | 16 | Software write data |
| rd_data | output | 16 | Current data register contents |
| count_out | output | 16 | Current counter value |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Compare mode is run with a small non-zero reload value, which shows whether the first reload after reset, the decrement and the D+1 period are each placed in the right cycle. Toggling tmr_in in compare mode then shows that the register ignores edges in that role. In capture mode, rising, falling, both and none are each driven with both polarities of input change, and each capture value is predicted from the cycle at which capture was entered, which pins down the synchroniser latency and the edge filtering. Byte-lane writes, full writes with stray enables, a write that collides with a capture, and a run through the 0xFFFF wrap cover the remaining corners.

// File: rtl/timer_cc_pkg.sv
package timer_cc_pkg;

  // Capture edge selection codes
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int unsigned LANE_BITS = 8;

endpackage

// File: rtl/timer_cc_edge_det.sv
// Multi-flop synchroniser followed by a one-flop edge detector.
module timer_cc_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o,
  output logic fall_o
);

  // pipe_q[STAGES-1] is the synchronised level, pipe_q[STAGES] its previous value
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rise_o =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] &  pipe_q[STAGES];

endmodule

// File: rtl/timer_cc_counter.sv
// Channel counter: down-count with reload in compare role, free-running up-count in capture role.
module timer_cc_counter #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_mode,
  input  logic             mode_chg,
  input  logic [WIDTH-1:0] reload_val,
  output logic [WIDTH-1:0] cnt_o,
  output logic             reload_o
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign reload_o = ~cap_mode & ~mode_chg & at_zero;

  always_comb begin
    if (mode_chg) begin
      cnt_d = '0;
    end else if (cap_mode) begin
      cnt_d = cnt_q + WIDTH'(1);
    end else if (at_zero) begin
      cnt_d = reload_val;
    end else begin
      cnt_d = cnt_q - WIDTH'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/timer_cc_datareg.sv
// Data register built from byte lanes; capture has priority over software writes.
module timer_cc_datareg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     wr_en,
  input  logic [WIDTH/timer_cc_pkg::LANE_BITS-1:0] wr_be,
  input  logic                                     split_en,
  input  logic [WIDTH-1:0]                         wr_data,
  input  logic                                     cap_fire,
  input  logic [WIDTH-1:0]                         cap_val,
  output logic [WIDTH-1:0]                         data_o
);

  import timer_cc_pkg::*;

  localparam int unsigned LANES = WIDTH / LANE_BITS;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic                 lane_we;
    logic                 lane_en;
    logic [LANE_BITS-1:0] lane_d;
    logic [LANE_BITS-1:0] lane_q;

    assign lane_we = wr_en & (split_en ? wr_be[gi] : 1'b1);
    assign lane_en = cap_fire | lane_we;

    always_comb begin
      if (cap_fire) begin
        lane_d = cap_val[gi*LANE_BITS +: LANE_BITS];
      end else begin
        lane_d = wr_data[gi*LANE_BITS +: LANE_BITS];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (lane_en) begin
        lane_q <= lane_d;
      end
    end

    assign data_o[gi*LANE_BITS +: LANE_BITS] = lane_q;
  end

endmodule

// File: rtl/timer_cc_channel.sv
// Top: one timer channel with a shared capture/compare data register.
module timer_cc_channel #(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_capture,
  input  logic [1:0]           edge_sel,
  input  logic                 split_en,
  input  logic                 tmr_in,
  input  logic                 wr_en,
  input  logic [WIDTH/8-1:0]   wr_be,
  input  logic [WIDTH-1:0]     wr_data,
  output logic [WIDTH-1:0]     rd_data,
  output logic [WIDTH-1:0]     count_out,
  output logic                 irq
);

  import timer_cc_pkg::*;

  logic mode_q;
  logic mode_chg;
  logic rise;
  logic fall;
  logic edge_hit;
  logic cap_fire;
  logic reload;
  logic irq_d;
  logic irq_q;

  assign mode_chg = mode_capture ^ mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else begin
      mode_q <= mode_capture;
    end
  end

  timer_cc_edge_det #(
    .STAGES (SYNC_STAGES)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (tmr_in),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  always_comb begin
    case (edge_sel_e'(edge_sel))
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  end

  assign cap_fire = mode_capture & ~mode_chg & edge_hit;

  timer_cc_counter #(
    .WIDTH (WIDTH)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_mode   (mode_capture),
    .mode_chg   (mode_chg),
    .reload_val (rd_data),
    .cnt_o      (count_out),
    .reload_o   (reload)
  );

  timer_cc_datareg #(
    .WIDTH (WIDTH)
  ) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_be    (wr_be),
    .split_en (split_en),
    .wr_data  (wr_data),
    .cap_fire (cap_fire),
    .cap_val  (count_out),
    .data_o   (rd_data)
  );

  assign irq_d = cap_fire | reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/timer_cc_channel_chk.sv
// Property checker attached to the channel top.
module timer_cc_channel_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_capture,
  input logic             mode_q,
  input logic             split_en,
  input logic             wr_en,
  input logic             wr_be_top,
  input logic             cap_fire,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] count_out,
  input logic             irq
);

  logic steady_cmp;
  logic steady_cap;

  assign steady_cmp = ~mode_capture & ~mode_q;
  assign steady_cap =  mode_capture &  mode_q;

  assert_down_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (steady_cmp && count_out != '0) |=> (count_out == $past(count_out) - WIDTH'(1)));

  assert_reload_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (steady_cmp && count_out == '0) |=> (irq && count_out == $past(rd_data)));

  assert_cmp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_capture && !wr_en) |=> $stable(rd_data));

  assert_capture_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (irq && rd_data == $past(count_out)));

  assert_up_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    steady_cap |=> (count_out == $past(count_out) + WIDTH'(1)));

  assert_lane_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && split_en && !wr_be_top && !cap_fire) |=>
      (rd_data[WIDTH-1 -: 8] == $past(rd_data[WIDTH-1 -: 8])));

  assert_cap_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && wr_en) |=> (rd_data == $past(count_out)));

endmodule

bind timer_cc_channel timer_cc_channel_chk #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_capture (mode_capture),
  .mode_q       (mode_q),
  .split_en     (split_en),
  .wr_en        (wr_en),
  .wr_be_top    (wr_be[WIDTH/8-1]),
  .cap_fire     (cap_fire),
  .rd_data      (rd_data),
  .count_out    (count_out),
  .irq          (irq)
);

// File: tb/timer_cc_channel_tb.sv
module timer_cc_channel_tb;

  localparam int CLK_PERIOD = 10;
  localparam int F_RD  = 0;
  localparam int F_CNT = 1;
  localparam int F_IRQ = 2;

  logic        clk;
  logic        rst_n;
  logic        mode_capture;
  logic [1:0]  edge_sel;
  logic        split_en;
  logic        tmr_in;
  logic        wr_en;
  logic [1:0]  wr_be;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [15:0] count_out;
  logic        irq;

  timer_cc_channel u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_capture (mode_capture),
    .edge_sel     (edge_sel),
    .split_en     (split_en),
    .tmr_in       (tmr_in),
    .wr_en        (wr_en),
    .wr_be        (wr_be),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .count_out    (count_out),
    .irq          (irq)
  );

  typedef struct {
    int          cyc;
    int          fld;
    logic [15:0] val;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          cyc;
  int          n_vec;
  int          n_bad;
  int          csw;
  logic [15:0] exp_rd;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(int off, int fld, logic [15:0] v, string req);
    exp_t it;
    it.cyc = cyc + off;
    it.fld = fld;
    it.val = v;
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic push_abs(int at, int fld, logic [15:0] v, string req);
    exp_t it;
    it.cyc = at;
    it.fld = fld;
    it.val = v;
    it.req = req;
    sb.push_back(it);
  endtask

  // Monitor: pops every item due in the current cycle and compares it
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc) begin
        case (sb[i].fld)
          F_RD:    check(sb[i].req, rd_data, sb[i].val);
          F_CNT:   check(sb[i].req, count_out, sb[i].val);
          default: check(sb[i].req, {15'd0, irq}, sb[i].val);
        endcase
        sb.delete(i);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive tmr_in to a new level; predict capture three edges later
  task automatic cap_event(logic lvl, bit hit, string req);
    tmr_in = lvl;
    if (hit) begin
      exp_rd = 16'(cyc + 1 - csw);
      push(3, F_RD, exp_rd, req);
      push(3, F_IRQ, 16'd1, req);
      push(4, F_IRQ, 16'd0, req);
    end else begin
      push(3, F_RD, exp_rd, req);
      push(3, F_IRQ, 16'd0, req);
      push(4, F_RD, exp_rd, req);
    end
    tick(6);
  endtask

  initial begin
    n_vec = 0;
    n_bad = 0;
    rst_n = 1'b0;
    mode_capture = 1'b0;
    edge_sel = 2'b00;
    split_en = 1'b0;
    tmr_in = 1'b0;
    wr_en = 1'b0;
    wr_be = 2'b00;
    wr_data = 16'h0000;
    tick(3);
    check("R1", rd_data, 16'h0000);
    check("R1", count_out, 16'h0000);
    check("R1", {15'd0, irq}, 16'd0);

    // Compare role, reload value 3; byte enables zero but split off (R2)
    rst_n = 1'b1;
    wr_en = 1'b1;
    wr_data = 16'h0003;
    exp_rd = 16'h0003;
    push(1, F_RD,  16'h0003, "R2");
    push(1, F_IRQ, 16'd1, "R4");
    push(2, F_CNT, 16'd3, "R4");
    push(2, F_IRQ, 16'd1, "R4");
    push(3, F_CNT, 16'd2, "R3");
    push(3, F_IRQ, 16'd0, "R3");
    push(4, F_CNT, 16'd1, "R3");
    push(5, F_CNT, 16'd0, "R3");
    push(5, F_IRQ, 16'd0, "R4");
    push(6, F_CNT, 16'd3, "R4");
    push(6, F_IRQ, 16'd1, "R4");
    push(7, F_IRQ, 16'd0, "R4");
    push(10, F_IRQ, 16'd1, "R4");
    tick(1);
    wr_en = 1'b0;
    tick(12);

    // Compare role ignores edges on the timer input (R5)
    edge_sel = 2'b11;
    tmr_in = 1'b1;
    tick(3);
    tmr_in = 1'b0;
    tick(3);
    tmr_in = 1'b1;
    tick(3);
    tmr_in = 1'b0;
    push(5, F_RD, 16'h0003, "R5");
    tick(8);

    // Enter capture role (R7)
    edge_sel = 2'b01;
    mode_capture = 1'b1;
    csw = cyc;
    push(1, F_CNT, 16'd0, "R7");
    push(1, F_IRQ, 16'd0, "R7");
    push(5, F_CNT, 16'd4, "R7");
    tick(10);

    // Rising only
    cap_event(1'b1, 1'b1, "R6");
    cap_event(1'b0, 1'b0, "R8");
    // Falling only
    edge_sel = 2'b10;
    cap_event(1'b1, 1'b0, "R8");
    cap_event(1'b0, 1'b1, "R8");
    // Both edges
    edge_sel = 2'b11;
    cap_event(1'b1, 1'b1, "R8");
    cap_event(1'b0, 1'b1, "R8");
    // No edge
    edge_sel = 2'b00;
    cap_event(1'b1, 1'b0, "R8");
    cap_event(1'b0, 1'b0, "R8");

    // Capture and write collide (R10)
    edge_sel = 2'b11;
    tmr_in = 1'b1;
    exp_rd = 16'(cyc + 1 - csw);
    tick(2);
    wr_en = 1'b1;
    wr_data = 16'h5A5A;
    push(1, F_RD, exp_rd, "R10");
    tick(1);
    wr_en = 1'b0;
    tick(4);

    // Byte-lane writes (R9)
    edge_sel = 2'b00;
    split_en = 1'b1;
    wr_en = 1'b1;
    wr_be = 2'b01;
    wr_data = 16'hABCD;
    exp_rd = {exp_rd[15:8], 8'hCD};
    push(1, F_RD, exp_rd, "R9");
    tick(1);
    wr_be = 2'b10;
    wr_data = 16'h1234;
    exp_rd = {8'h12, exp_rd[7:0]};
    push(1, F_RD, exp_rd, "R9");
    tick(1);
    wr_be = 2'b00;
    wr_data = 16'hFFFF;
    push(1, F_RD, exp_rd, "R9");
    tick(1);
    // Split off: stray single enable still writes whole word (R2)
    split_en = 1'b0;
    wr_be = 2'b01;
    wr_data = 16'h0F0F;
    exp_rd = 16'h0F0F;
    push(1, F_RD, exp_rd, "R2");
    tick(1);
    wr_en = 1'b0;
    wr_be = 2'b00;
    tick(3);

    // Wrap of the up-counter (R7)
    while (cyc < csw + 65530) tick(1);
    push_abs(csw + 65536, F_CNT, 16'hFFFF, "R7");
    push_abs(csw + 65537, F_CNT, 16'h0000, "R7");
    tick(10);

    if (sb.size() != 0) begin
      n_bad += sb.size();
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule